// File: doc/BRIEF.md
# Processor run-control coprocessor

This block sits between a host command channel and a small multi-cycle processor core. The host sends command records over a valid/ready channel. Each record carries a 32-bit value, an address, a copy of that address, a valid flag and a target selector. Memory commands load and read back the instruction and data memories, which live inside the block as inferable RAM. The core fetches from the instruction memory and reads and writes the data memory through word-indexed ports of its own.

Control commands work through a 32-bit argument register. The host loads a value into it and then copies it into the core's program counter. The host can also start a free run, start a run that ends after a given number of clock cycles, or halt the core. While the core runs, the block counts clock cycles and retired instructions. When the core retires the stop instruction, or when a bounded run runs out, the run ends, an interrupt pulse goes to the host and a status bit records the cause.

Read requests, counter and status queries, and rejected commands each produce one tagged response record, with at most one response outstanding. Host writes never produce a response.

Top module: `runctl_coproc`

## Requirements
- R1: After reset, core_run, irq, core_pc_load and rsp_valid are 0 and cmd_ready is 1.
- R2: A command accepted with cmd_flag = 0 is dropped. It produces no response and changes no memory or register.
- R3: An error response (type 0xE, data = command value, address = command address) is returned, with no other effect, in these cases: cmd_addr differs from cmd_addr_dup; a memory address is not a multiple of 4 or lies beyond the memory; the selector is not one of 0, 1, 2, 4, 5; or the control opcode is above 7.
- R4: Selector 0 writes the instruction memory and selector 1 writes the data memory, both without a response. Selector 4 reads the instruction memory and selector 5 reads the data memory. A read returns type 1, the stored word and the byte address read. Word n sits at byte address 4n.
- R5: Selector 2 is a control command, with the opcode in cmd_data[3:0] and the argument in cmd_addr. Opcode 0 loads cmd_addr into the argument register. Opcode 2 drives core_pc_load high for exactly one cycle, with core_pc_value equal to the argument register, in the cycle after acceptance.
- R6: Opcode 1 starts a free run. core_run is 1 from the cycle after acceptance, and both counters restart from 0.
- R7: When the core retires the word 0x40800000 while running, core_run drops after that edge. irq is then 1 for exactly one cycle, and status bit 1 is set.
- R8: Opcode 4 starts a bounded run of N = cmd_addr cycles. core_run stays high for exactly N cycles, then irq pulses for one cycle and status bit 2 is set.
- R9: Opcode 4 with N = 0 returns an error response and does not start the core.
- R10: Opcode 5 returns the cycle count and opcode 6 returns the instruction count, both as type 2. Status is read with opcode 7 as type 3: bit 0 is running, bit 1 is stop instruction, bit 2 is cycle limit. The cycle count equals the number of cycles core_run was 1. The instruction count equals the retire pulses seen while running, the stop word included. Both stay frozen after a halt.
- R11: While the core runs, memory writes, PC loads and start commands return an error response and have no effect.
- R12: While a response is pending, cmd_ready is 0. The response fields stay unchanged until rsp_ready is seen.
- R13: Opcode 3 halts a running core without raising irq and without setting either cause bit.
- R14: core_fetch_word and core_dmem_rdata show the word at the index given in the previous cycle. A core data write (core_dmem_we) is honoured only while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command record present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_data | input | 32 | Command value / control opcode |
| cmd_addr | input | 32 | Byte address or control argument |
| cmd_addr_dup | input | 32 | Copy of cmd_addr, must match |
| cmd_flag | input | 1 | Record valid flag, must be 1 |
| cmd_sel | input | 3 | Target selector |
| rsp_valid | output | 1 | Response record present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 32 | Response data |
| rsp_type | output | 4 | Response type tag |
| rsp_addr | output | 32 | Address echoed in the response |
| irq | output | 1 | One-cycle run-ended interrupt |
| core_run | output | 1 | Core enabled to execute |
| core_pc_load | output | 1 | Load program counter pulse |
| core_pc_value | output | 32 | Program counter value |
| core_fetch_idx | input | IMEM_IW | Core fetch word index |
| core_fetch_word | output | 32 | Fetched instruction word |
| core_dmem_idx | input | DMEM_IW | Core data word index |
| core_dmem_we | input | 1 | Core data write enable |
| core_dmem_wdata | input | 32 | Core data write value |
| core_dmem_rdata | output | 32 | Core data read value |
| core_retire | input | 1 | Instruction retired this cycle |
| core_instr | input | 32 | Word of the retiring instruction |

## Verification
The stop instruction and the end of a bounded run can arrive on the same clock edge. Two halt causes then meet the single interrupt path. The bench starts a three-cycle bounded run and retires the stop word in its third cycle. It expects core_run to drop once, irq to pulse for one cycle only, status to read 0x6 with both cause bits set, and the counters to read three cycles and one instruction.

// File: rtl/runctl_pkg.sv
package runctl_pkg;
  localparam logic [31:0] STOP_WORD = 32'h4080_0000;

  localparam logic [2:0] SEL_IMEM_WR = 3'd0;
  localparam logic [2:0] SEL_DMEM_WR = 3'd1;
  localparam logic [2:0] SEL_CTRL    = 3'd2;
  localparam logic [2:0] SEL_IMEM_RD = 3'd4;
  localparam logic [2:0] SEL_DMEM_RD = 3'd5;

  typedef enum logic [3:0] {
    OP_ARG     = 4'd0,
    OP_GO      = 4'd1,
    OP_PCLOAD  = 4'd2,
    OP_HALT    = 4'd3,
    OP_GO_LIM  = 4'd4,
    OP_RD_CYC  = 4'd5,
    OP_RD_INS  = 4'd6,
    OP_RD_STAT = 4'd7
  } ctl_op_e;

  localparam logic [3:0] RSP_MEM  = 4'h1;
  localparam logic [3:0] RSP_CNT  = 4'h2;
  localparam logic [3:0] RSP_STAT = 4'h3;
  localparam logic [3:0] RSP_ERR  = 4'hE;
endpackage

// File: rtl/runctl_ram.sv
module runctl_ram #(
  parameter int WORDS = 256,
  parameter int DW    = 32,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re_a,
  input  logic [IW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [IW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re_a) rdata_a <= mem[raddr_a];
  end

  always_ff @(posedge clk) begin
    rdata_b <= mem[raddr_b];
  end
endmodule

// File: rtl/runctl_cnt.sv
module runctl_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst || clr) value <= '0;
    else if (inc)   value <= value + W'(1);
  end
endmodule

// File: rtl/runctl_seq.sv
module runctl_seq
  import runctl_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_free,
  input  logic             go_lim,
  input  logic [CNT_W-1:0] lim_val,
  input  logic             host_halt,
  input  logic             pc_ld,
  input  logic             arg_we,
  input  logic [31:0]      arg_val,
  input  logic             retire,
  input  logic [31:0]      instr,
  output logic             run,
  output logic             irq,
  output logic             pc_load,
  output logic [31:0]      pc_value,
  output logic             why_stop,
  output logic             why_lim
);
  logic             bounded;
  logic [CNT_W-1:0] remain;
  logic [31:0]      arg_q;
  logic             stop_hit;
  logic             lim_hit;

  assign stop_hit = retire && (instr == STOP_WORD);
  assign lim_hit  = bounded && (remain == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      irq      <= 1'b0;
      bounded  <= 1'b0;
      remain   <= '0;
      arg_q    <= '0;
      pc_load  <= 1'b0;
      pc_value <= '0;
      why_stop <= 1'b0;
      why_lim  <= 1'b0;
    end else begin
      irq     <= 1'b0;
      pc_load <= pc_ld;
      if (pc_ld)  pc_value <= arg_q;
      if (arg_we) arg_q    <= arg_val;
      if (go_free || go_lim) begin
        run      <= 1'b1;
        bounded  <= go_lim;
        remain   <= lim_val;
        why_stop <= 1'b0;
        why_lim  <= 1'b0;
      end else if (run) begin
        if (bounded) remain <= remain - CNT_W'(1);
        if (stop_hit || lim_hit) begin
          run      <= 1'b0;
          irq      <= 1'b1;
          why_stop <= stop_hit;
          why_lim  <= lim_hit;
        end else if (host_halt) begin
          run <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/runctl_coproc.sv
module runctl_coproc
  import runctl_pkg::*;
#(
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 256,
  parameter int CNT_W      = 32,
  localparam int IMEM_IW   = $clog2(IMEM_WORDS),
  localparam int DMEM_IW   = $clog2(DMEM_WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [31:0]        cmd_data,
  input  logic [31:0]        cmd_addr,
  input  logic [31:0]        cmd_addr_dup,
  input  logic               cmd_flag,
  input  logic [2:0]         cmd_sel,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [31:0]        rsp_data,
  output logic [3:0]         rsp_type,
  output logic [31:0]        rsp_addr,
  output logic               irq,
  output logic               core_run,
  output logic               core_pc_load,
  output logic [31:0]        core_pc_value,
  input  logic [IMEM_IW-1:0] core_fetch_idx,
  output logic [31:0]        core_fetch_word,
  input  logic [DMEM_IW-1:0] core_dmem_idx,
  input  logic               core_dmem_we,
  input  logic [31:0]        core_dmem_wdata,
  output logic [31:0]        core_dmem_rdata,
  input  logic               core_retire,
  input  logic [31:0]        core_instr
);
  logic take, dup_ok, ia_ok, da_ok;
  logic [IMEM_IW-1:0] h_iidx;
  logic [DMEM_IW-1:0] h_didx;
  logic imem_hwe, dmem_hwe, rd_imem, rd_dmem, rd_ctl, err;
  logic [31:0] ctl_data;
  logic [3:0]  ctl_type;
  logic go_free, go_lim, host_halt, pc_ld, arg_we;
  logic rd_pend, rd_src;
  logic [31:0] rd_addr_q;
  logic [31:0] imem_a, dmem_a;
  logic [CNT_W-1:0] cyc_cnt, ins_cnt;
  logic why_stop, why_lim;
  logic dmem_we;
  logic [DMEM_IW-1:0] dmem_waddr;
  logic [31:0] dmem_wdata;
  ctl_op_e op;

  assign cmd_ready = !rsp_valid && !rd_pend;
  assign take      = cmd_valid && cmd_ready && cmd_flag;
  assign dup_ok    = (cmd_addr == cmd_addr_dup);
  assign ia_ok     = dup_ok && (cmd_addr[1:0] == 2'b00) && ((cmd_addr >> (IMEM_IW + 2)) == 32'd0);
  assign da_ok     = dup_ok && (cmd_addr[1:0] == 2'b00) && ((cmd_addr >> (DMEM_IW + 2)) == 32'd0);
  assign h_iidx    = cmd_addr[IMEM_IW+1:2];
  assign h_didx    = cmd_addr[DMEM_IW+1:2];
  assign op        = ctl_op_e'(cmd_data[3:0]);

  always_comb begin
    imem_hwe  = 1'b0;
    dmem_hwe  = 1'b0;
    rd_imem   = 1'b0;
    rd_dmem   = 1'b0;
    rd_ctl    = 1'b0;
    err       = 1'b0;
    go_free   = 1'b0;
    go_lim    = 1'b0;
    host_halt = 1'b0;
    pc_ld     = 1'b0;
    arg_we    = 1'b0;
    ctl_data  = 32'd0;
    ctl_type  = RSP_CNT;
    if (take) begin
      case (cmd_sel)
        SEL_IMEM_WR: if (!ia_ok || core_run) err = 1'b1; else imem_hwe = 1'b1;
        SEL_DMEM_WR: if (!da_ok || core_run) err = 1'b1; else dmem_hwe = 1'b1;
        SEL_IMEM_RD: if (!ia_ok) err = 1'b1; else rd_imem = 1'b1;
        SEL_DMEM_RD: if (!da_ok) err = 1'b1; else rd_dmem = 1'b1;
        SEL_CTRL: begin
          if (!dup_ok || (cmd_data[31:4] != 28'd0)) begin
            err = 1'b1;
          end else begin
            case (op)
              OP_ARG:     arg_we = 1'b1;
              OP_GO:      if (core_run) err = 1'b1; else go_free = 1'b1;
              OP_PCLOAD:  if (core_run) err = 1'b1; else pc_ld = 1'b1;
              OP_HALT:    host_halt = 1'b1;
              OP_GO_LIM:  if (core_run || cmd_addr == 32'd0) err = 1'b1; else go_lim = 1'b1;
              OP_RD_CYC:  begin rd_ctl = 1'b1; ctl_data = 32'(cyc_cnt); end
              OP_RD_INS:  begin rd_ctl = 1'b1; ctl_data = 32'(ins_cnt); end
              OP_RD_STAT: begin
                rd_ctl   = 1'b1;
                ctl_type = RSP_STAT;
                ctl_data = {29'd0, why_lim, why_stop, core_run};
              end
              default:    err = 1'b1;
            endcase
          end
        end
        default: err = 1'b1;
      endcase
    end
  end

  // Host writes happen only while halted, core writes only while running.
  assign dmem_we    = dmem_hwe || (core_run && core_dmem_we);
  assign dmem_waddr = dmem_hwe ? h_didx : core_dmem_idx;
  assign dmem_wdata = dmem_hwe ? cmd_data : core_dmem_wdata;

  runctl_ram #(.WORDS(IMEM_WORDS), .DW(32)) imem_i (
    .clk(clk), .we(imem_hwe), .waddr(h_iidx), .wdata(cmd_data),
    .re_a(rd_imem), .raddr_a(h_iidx), .rdata_a(imem_a),
    .raddr_b(core_fetch_idx), .rdata_b(core_fetch_word)
  );

  runctl_ram #(.WORDS(DMEM_WORDS), .DW(32)) dmem_i (
    .clk(clk), .we(dmem_we), .waddr(dmem_waddr), .wdata(dmem_wdata),
    .re_a(rd_dmem), .raddr_a(h_didx), .rdata_a(dmem_a),
    .raddr_b(core_dmem_idx), .rdata_b(core_dmem_rdata)
  );

  runctl_seq #(.CNT_W(CNT_W)) seq_i (
    .clk(clk), .rst(rst), .go_free(go_free), .go_lim(go_lim),
    .lim_val(CNT_W'(cmd_addr)), .host_halt(host_halt), .pc_ld(pc_ld),
    .arg_we(arg_we), .arg_val(cmd_addr), .retire(core_retire),
    .instr(core_instr), .run(core_run), .irq(irq), .pc_load(core_pc_load),
    .pc_value(core_pc_value), .why_stop(why_stop), .why_lim(why_lim)
  );

  runctl_cnt #(.W(CNT_W)) cyc_i (
    .clk(clk), .rst(rst), .clr(go_free || go_lim), .inc(core_run), .value(cyc_cnt)
  );

  runctl_cnt #(.W(CNT_W)) ins_i (
    .clk(clk), .rst(rst), .clr(go_free || go_lim), .inc(core_run && core_retire),
    .value(ins_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_type  <= '0;
      rsp_addr  <= '0;
      rd_pend   <= 1'b0;
      rd_src    <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      rd_pend <= rd_imem || rd_dmem;
      if (rd_imem || rd_dmem) begin
        rd_src    <= rd_dmem;
        rd_addr_q <= cmd_addr;
      end
      if (rd_pend) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd_src ? dmem_a : imem_a;
        rsp_type  <= RSP_MEM;
        rsp_addr  <= rd_addr_q;
      end else if (err) begin
        rsp_valid <= 1'b1;
        rsp_data  <= cmd_data;
        rsp_type  <= RSP_ERR;
        rsp_addr  <= cmd_addr;
      end else if (rd_ctl) begin
        rsp_valid <= 1'b1;
        rsp_data  <= ctl_data;
        rsp_type  <= ctl_type;
        rsp_addr  <= cmd_addr;
      end
    end
  end
endmodule

// File: rtl/runctl_chk.sv
module runctl_chk (
  input logic        clk,
  input logic        rst,
  input logic        cmd_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_data,
  input logic [3:0]  rsp_type,
  input logic [31:0] rsp_addr,
  input logic        irq,
  input logic        core_run,
  input logic        core_pc_load
);
  AST_IRQ_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (!core_run && $past(core_run))); // R7
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R8
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_type) && $stable(rsp_addr))); // R12
  AST_NO_TAKE_PENDING: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !cmd_ready); // R12
  AST_PCLOAD_HALTED: assert property (@(posedge clk) disable iff (rst)
    core_pc_load |-> !core_run); // R11
endmodule

bind runctl_coproc runctl_chk chk_i (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_type(rsp_type),
  .rsp_addr(rsp_addr), .irq(irq), .core_run(core_run),
  .core_pc_load(core_pc_load)
);

// File: tb/runctl_coproc_tb_top.sv
module runctl_coproc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] STOPW = 32'h4080_0000;
  // {selector, byte address, value}
  localparam logic [66:0] VEC [6] = '{
    {3'd0, 32'h0000_0000, 32'h1111_0001},
    {3'd0, 32'h0000_0010, 32'h2222_0010},
    {3'd0, 32'h0000_03FC, 32'h3333_03FC},
    {3'd1, 32'h0000_0000, 32'hAAAA_0000},
    {3'd1, 32'h0000_0004, 32'hBBBB_0004},
    {3'd1, 32'h0000_03FC, 32'hCCCC_03FC}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_ready, cmd_flag = 1'b0;
  logic [31:0] cmd_data = '0, cmd_addr = '0, cmd_addr_dup = '0;
  logic [2:0] cmd_sel = '0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [31:0] rsp_data, rsp_addr;
  logic [3:0] rsp_type;
  logic irq, core_run, core_pc_load;
  logic [31:0] core_pc_value, core_fetch_word, core_dmem_rdata;
  logic [7:0] core_fetch_idx = '0, core_dmem_idx = '0;
  logic core_dmem_we = 1'b0, core_retire = 1'b0;
  logic [31:0] core_dmem_wdata = '0, core_instr = '0;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] r_data, r_addr;
  logic [3:0] r_type;

  always #(CLK_PERIOD/2) clk = ~clk;

  runctl_coproc #(.IMEM_WORDS(256), .DMEM_WORDS(256), .CNT_W(32)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .cmd_addr(cmd_addr), .cmd_addr_dup(cmd_addr_dup),
    .cmd_flag(cmd_flag), .cmd_sel(cmd_sel), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_type(rsp_type),
    .rsp_addr(rsp_addr), .irq(irq), .core_run(core_run),
    .core_pc_load(core_pc_load), .core_pc_value(core_pc_value),
    .core_fetch_idx(core_fetch_idx), .core_fetch_word(core_fetch_word),
    .core_dmem_idx(core_dmem_idx), .core_dmem_we(core_dmem_we),
    .core_dmem_wdata(core_dmem_wdata), .core_dmem_rdata(core_dmem_rdata),
    .core_retire(core_retire), .core_instr(core_instr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] s, input logic [31:0] d, input logic [31:0] a,
                      input logic [31:0] a2, input logic f);
    @(negedge clk);
    cmd_sel = s; cmd_data = d; cmd_addr = a; cmd_addr_dup = a2; cmd_flag = f;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic ctl(input logic [31:0] op, input logic [31:0] arg);
    send(3'd2, op, arg, arg, 1'b1);
  endtask

  task automatic get_rsp;
    while (!rsp_valid) @(negedge clk);
    r_data = rsp_data; r_type = rsp_type; r_addr = rsp_addr;
  endtask

  task automatic expect_err(input string tag, input logic [31:0] d, input logic [31:0] a);
    get_rsp();
    check({tag, " type"}, {28'd0, r_type}, 32'hE);
    check({tag, " data"}, r_data, d);
    check({tag, " addr"}, r_addr, a);
  endtask

  task automatic expect_none(input string tag);
    repeat (2) begin
      check(tag, {31'd0, rsp_valid}, 32'd0);
      @(negedge clk);
    end
  endtask

  task automatic read_ctl(input logic [31:0] op, output logic [31:0] val);
    ctl(op, 32'd0);
    get_rsp();
    val = r_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cnt;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 core_run", {31'd0, core_run}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 pc_load", {31'd0, core_pc_load}, 32'd0);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 cmd_ready", {31'd0, cmd_ready}, 32'd1);
    rst = 1'b0;

    // R4 vector table: write all, then read each back
    for (int i = 0; i < 6; i++) begin
      send(VEC[i][66:64], VEC[i][31:0], VEC[i][63:32], VEC[i][63:32], 1'b1);
      expect_none("R4 write gives no response");
    end
    for (int i = 0; i < 6; i++) begin
      send(VEC[i][66:64] | 3'd4, 32'd0, VEC[i][63:32], VEC[i][63:32], 1'b1);
      get_rsp();
      check("R4 read type", {28'd0, r_type}, 32'h1);
      check("R4 read data", r_data, VEC[i][31:0]);
      check("R4 read addr", r_addr, VEC[i][63:32]);
    end

    // R2 flag=0 dropped
    send(3'd0, 32'hDEAD_BEEF, 32'h10, 32'h10, 1'b0);
    expect_none("R2 no response");
    send(3'd4, 32'd0, 32'h10, 32'h10, 1'b1);
    get_rsp();
    check("R2 memory unchanged", r_data, 32'h2222_0010);

    // R3 error cases
    send(3'd1, 32'h5555_5555, 32'h8, 32'hC, 1'b1);
    expect_err("R3 dup mismatch", 32'h5555_5555, 32'h8);
    send(3'd4, 32'h0, 32'h6, 32'h6, 1'b1);
    expect_err("R3 misaligned", 32'h0, 32'h6);
    send(3'd5, 32'h0, 32'h400, 32'h400, 1'b1);
    expect_err("R3 out of range", 32'h0, 32'h400);
    send(3'd3, 32'h7, 32'h0, 32'h0, 1'b1);
    expect_err("R3 bad selector", 32'h7, 32'h0);
    ctl(32'd9, 32'h0);
    expect_err("R3 bad opcode", 32'd9, 32'h0);
    send(3'd5, 32'd0, 32'h8, 32'h8, 1'b1);
    get_rsp();
    check("R3 rejected write had no effect", r_data === 32'h5555_5555 ? 32'd1 : 32'd0, 32'd0);

    // R14 core fetch port
    @(negedge clk);
    core_fetch_idx = 8'd4;
    @(negedge clk);
    check("R14 fetch word", core_fetch_word, 32'h2222_0010);

    // R5 argument and PC load
    ctl(32'd0, 32'h100);
    ctl(32'd2, 32'h0);
    check("R5 pc_load high", {31'd0, core_pc_load}, 32'd1);
    check("R5 pc value", core_pc_value, 32'h100);
    @(negedge clk);
    check("R5 pc_load one cycle", {31'd0, core_pc_load}, 32'd0);

    // R6 R7 R10 R14 free run ended by stop word
    ctl(32'd1, 32'h0);
    check("R6 run after start", {31'd0, core_run}, 32'd1);
    core_retire = 1'b1; core_instr = 32'h0000_1234;
    @(negedge clk);
    core_retire = 1'b0; core_dmem_we = 1'b1; core_dmem_idx = 8'd8; core_dmem_wdata = 32'hCAFE_0020;
    @(negedge clk);
    core_dmem_we = 1'b0; core_retire = 1'b1; core_instr = 32'h0000_5678;
    @(negedge clk);
    core_retire = 1'b0;
    @(negedge clk);
    check("R6 still running", {31'd0, core_run}, 32'd1);
    core_retire = 1'b1; core_instr = STOPW;
    @(negedge clk);
    core_retire = 1'b0;
    check("R7 run dropped", {31'd0, core_run}, 32'd0);
    check("R7 irq raised", {31'd0, irq}, 32'd1);
    check("R14 core data read", core_dmem_rdata, 32'hCAFE_0020);
    @(negedge clk);
    check("R7 irq one cycle", {31'd0, irq}, 32'd0);
    core_retire = 1'b1; core_instr = 32'h1;
    @(negedge clk);
    core_retire = 1'b0;
    read_ctl(32'd7, v);
    check("R7 status stop bit", v, 32'h2);
    read_ctl(32'd5, v);
    check("R10 cycle count", v, 32'd5);
    check("R10 counter type", {28'd0, r_type}, 32'h2);
    read_ctl(32'd6, v);
    check("R10 instruction count frozen", v, 32'd3);
    send(3'd5, 32'd0, 32'h20, 32'h20, 1'b1);
    get_rsp();
    check("R14 core write landed", r_data, 32'hCAFE_0020);
    // R14 core write ignored while halted
    @(negedge clk);
    core_dmem_we = 1'b1; core_dmem_idx = 8'd8; core_dmem_wdata = 32'h0BAD_0BAD;
    @(negedge clk);
    core_dmem_we = 1'b0;
    @(negedge clk);
    check("R14 halted core write ignored", core_dmem_rdata, 32'hCAFE_0020);

    // R11 rejects while running, R13 host halt
    ctl(32'd1, 32'h0);
    send(3'd0, 32'h7777_7777, 32'h10, 32'h10, 1'b1);
    expect_err("R11 imem write", 32'h7777_7777, 32'h10);
    ctl(32'd2, 32'h0);
    expect_err("R11 pc load", 32'd2, 32'h0);
    ctl(32'd1, 32'h0);
    expect_err("R11 start", 32'd1, 32'h0);
    check("R11 still running", {31'd0, core_run}, 32'd1);
    ctl(32'd3, 32'h0);
    check("R13 halted", {31'd0, core_run}, 32'd0);
    check("R13 no irq", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R13 no irq later", {31'd0, irq}, 32'd0);
    read_ctl(32'd7, v);
    check("R13 status clear", v, 32'h0);
    send(3'd4, 32'd0, 32'h10, 32'h10, 1'b1);
    get_rsp();
    check("R11 imem unchanged", r_data, 32'h2222_0010);

    // R8 bounded run
    ctl(32'd4, 32'd4);
    cnt = 0;
    while (core_run) begin
      cnt++;
      @(negedge clk);
    end
    check("R8 run length", cnt, 32'd4);
    check("R8 irq at end", {31'd0, irq}, 32'd1);
    read_ctl(32'd7, v);
    check("R8 status limit bit", v, 32'h4);
    read_ctl(32'd5, v);
    check("R10 bounded cycle count", v, 32'd4);

    // R9 zero bound
    ctl(32'd4, 32'd0);
    expect_err("R9 zero bound", 32'd4, 32'd0);
    check("R9 not started", {31'd0, core_run}, 32'd0);

    // Stop word on the last bounded cycle
    ctl(32'd4, 32'd3);
    @(negedge clk);
    @(negedge clk);
    core_retire = 1'b1; core_instr = STOPW;
    @(negedge clk);
    core_retire = 1'b0;
    check("R8 R7 both halt run", {31'd0, core_run}, 32'd0);
    check("R8 R7 single irq", {31'd0, irq}, 32'd1);
    @(negedge clk);
    check("R8 R7 irq one cycle", {31'd0, irq}, 32'd0);
    read_ctl(32'd7, v);
    check("R8 R7 both cause bits", v, 32'h6);
    read_ctl(32'd5, v);
    check("R10 collision cycles", v, 32'd3);
    read_ctl(32'd6, v);
    check("R10 collision instrs", v, 32'd1);

    // R12 response hold
    @(negedge clk);
    rsp_ready = 1'b0;
    ctl(32'd6, 32'h0);
    check("R12 valid", {31'd0, rsp_valid}, 32'd1);
    repeat (3) @(negedge clk);
    check("R12 still valid", {31'd0, rsp_valid}, 32'd1);
    check("R12 ready low", {31'd0, cmd_ready}, 32'd0);
    check("R12 data held", rsp_data, 32'd1);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R12 released", {31'd0, rsp_valid}, 32'd0);
    check("R12 ready again", {31'd0, cmd_ready}, 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule